// File: doc/BRIEF.md
# Two-Clock FIFO with Selectable Output Discipline

This block carries data words from a write clock domain to an independent read clock domain. One storage array sits behind a registered output stage. The read side works in one of two disciplines, fixed when the block leaves reset. In look-ahead mode the oldest word is already at the output when the ready flag rises, and a read request consumes it. In request mode the ready flag only says that data is available, and every word, including the first, arrives at the output one read edge after an explicit request.

Pointers cross between the domains as Gray codes through two-stage synchronizers. Each flag is computed locally from its own pointer and the synchronized pointer of the other side. The write side has a single ready flag. A write request counts only while that flag is high. Depth must be a power of two, at least four.

Top module: `dual_mode_fifo`

## Requirements
- R1: While `rst_ni` is low, `wr_rdy_o` and `rd_rdy_o` are 0. `wr_rdy_o` rises at the first write-clock edge after release. `fwft_i` is sampled at the first read-clock edge after release (1 = look-ahead, 0 = request), and later changes of it have no effect until the next reset.
- R2: In request mode, after a write edge into an empty FIFO, `rd_rdy_o` is still 0 after the first read-clock rising edge and is 1 after the second.
- R3: In request mode, `rd_data_o` changes only at a read edge with `rd_en_i` and `rd_rdy_o` both high. It then takes the oldest unread word. It never changes just because data became available.
- R4: In look-ahead mode, after a write edge into an empty FIFO, `rd_rdy_o` is 0 after two read-clock edges. At the third edge it rises, and the written word appears on `rd_data_o` at that same edge.
- R5: In look-ahead mode, while `rd_rdy_o` is high and no read is requested, `rd_data_o` and `rd_rdy_o` hold. A read either loads the next word at that edge or, if none is available, drops `rd_rdy_o`.
- R6: A write with `wr_rdy_o` low is ignored. With no reads, the FIFO accepts exactly DEPTH words in request mode and DEPTH+1 in look-ahead mode, because the output register holds one word.
- R7: A read with `rd_rdy_o` low is ignored. `rd_data_o` is unchanged, and the next word written is the next one delivered.
- R8: Words come out in write order and bit-exact, including while writes and reads run at the same time on the two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| fwft_i | input | 1 | Read discipline select: 1 look-ahead, 0 request |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DW | Write data |
| wr_rdy_o | output | 1 | Write side may accept a word |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DW | Registered output word |
| rd_rdy_o | output | 1 | Look-ahead: word valid at output. Request mode: data available |

## Verification
A corrupted pointer or synchronizer state appears at `rd_data_o` as a skipped, repeated or reordered word on the very next delivery. It also shows in the count of writes accepted before `wr_rdy_o` falls. A flag-path error shows within two or three read edges of the first write, as `rd_rdy_o` rising one edge early or late or, in request mode, as the output changing without a request. A mode-capture fault makes one discipline behave like the other, so the latency checks in both modes expose it.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {
    MODE_REQ  = 1'b0,
    MODE_LOOK = 1'b1
  } rd_mode_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/dmf_sync.sv
module dmf_sync #(
  parameter int W      = 9,
  parameter int STAGES = dmf_pkg::SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dmf_mem.sv
module dmf_mem #(
  parameter int DW    = 36,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read address only points at words already published via the synced pointer
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dmf_wr_ctl.sv
module dmf_wr_ctl #(
  parameter int AW = 8
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW:0]   rptr_sync_g_i,
  output logic [AW:0]   wptr_g_o,
  output logic [AW-1:0] waddr_o,
  output logic          push_o,
  output logic          wr_rdy_o
);
  localparam logic [AW:0] CAP = (AW+1)'(1) << AW;

  logic [AW:0] wbin_q, wbin_nxt, wgray_q, rbin_sync;
  logic        rst_done_q, full;

  assign wbin_nxt = wbin_q + (AW+1)'(1);
  assign full     = (wgray_q == {~rptr_sync_g_i[AW:AW-1], rptr_sync_g_i[AW-2:0]});
  assign wr_rdy_o = rst_done_q && !full;
  assign push_o   = wr_en_i && wr_rdy_o;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_done_q <= 1'b0;
      wbin_q     <= '0;
      wgray_q    <= '0;
    end else begin
      rst_done_q <= 1'b1;
      if (push_o) begin
        wbin_q  <= wbin_nxt;
        wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
      end
    end
  end

  assign wptr_g_o = wgray_q;
  assign waddr_o  = wbin_q[AW-1:0];

  always_comb begin
    for (int i = 0; i <= AW; i++) rbin_sync[i] = ^(rptr_sync_g_i >> i);
  end

  assert_no_overflow_R6: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wbin_q - rbin_sync) <= CAP);

  assert_gray_step_R8: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $onehot0(wgray_q ^ $past(wgray_q)));
endmodule

// File: rtl/dmf_rd_ctl.sv
module dmf_rd_ctl
  import dmf_pkg::*;
#(
  parameter int DW = 36,
  parameter int AW = 8
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          rd_en_i,
  input  logic [AW:0]   wptr_sync_g_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rptr_g_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_rdy_o
);
  localparam logic [AW:0] CAP = (AW+1)'(1) << AW;

  rd_mode_e    mode_q;
  logic        arm_q, or_q, avail, load;
  logic [AW:0] rbin_q, rbin_nxt, rgray_q, wbin_sync;
  logic [DW-1:0] dout_q;

  // mode taken on the first read edge after reset release
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b1;
      mode_q <= MODE_REQ;
    end else begin
      arm_q <= 1'b0;
      if (arm_q) mode_q <= fwft_i ? MODE_LOOK : MODE_REQ;
    end
  end

  assign avail    = (rgray_q != wptr_sync_g_i);
  assign rbin_nxt = rbin_q + (AW+1)'(1);

  always_comb begin
    if (mode_q == MODE_LOOK) load = avail && (!or_q || rd_en_i);
    else                     load = avail && rd_en_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      or_q    <= 1'b0;
      dout_q  <= '0;
    end else begin
      if (load) begin
        dout_q  <= mem_rdata_i;
        rbin_q  <= rbin_nxt;
        rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
      end
      if (mode_q == MODE_LOOK) begin
        if (load)         or_q <= 1'b1;
        else if (rd_en_i) or_q <= 1'b0;
      end else begin
        or_q <= 1'b0;
      end
    end
  end

  assign rd_rdy_o  = (mode_q == MODE_LOOK) ? or_q : avail;
  assign rd_data_o = dout_q;
  assign raddr_o   = rbin_q[AW-1:0];
  assign rptr_g_o  = rgray_q;

  always_comb begin
    for (int i = 0; i <= AW; i++) wbin_sync[i] = ^(wptr_sync_g_i >> i);
  end

  assert_mode_stable_R1: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !arm_q |=> $stable(mode_q));

  assert_req_no_autoload_R3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (mode_q == MODE_REQ && !(rd_en_i && rd_rdy_o)) |=> $stable(rd_data_o));

  assert_look_hold_R5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (mode_q == MODE_LOOK && rd_rdy_o && !rd_en_i) |=> (rd_rdy_o && $stable(rd_data_o)));

  assert_no_underflow_R7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (wbin_sync - rbin_q) <= CAP);
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int DEPTH = 256,
  parameter int DW    = 36
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_rdy_o,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_rdy_o
);
  localparam int AW = $clog2(DEPTH);

  logic [AW:0]   wptr_g, rptr_g, wptr_sync_g, rptr_sync_g;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] mem_rdata;
  logic          push;

  dmf_wr_ctl #(.AW(AW)) i_wr_ctl (
    .wclk_i       (wclk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .rptr_sync_g_i(rptr_sync_g),
    .wptr_g_o     (wptr_g),
    .waddr_o      (waddr),
    .push_o       (push),
    .wr_rdy_o     (wr_rdy_o)
  );

  dmf_mem #(.DW(DW), .DEPTH(DEPTH)) i_mem (
    .wclk_i (wclk_i),
    .we_i   (push),
    .waddr_i(waddr),
    .wdata_i(wr_data_i),
    .raddr_i(raddr),
    .rdata_o(mem_rdata)
  );

  dmf_sync #(.W(AW+1)) i_sync_w2r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wptr_g),
    .q_o   (wptr_sync_g)
  );

  dmf_sync #(.W(AW+1)) i_sync_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (rptr_g),
    .q_o   (rptr_sync_g)
  );

  dmf_rd_ctl #(.DW(DW), .AW(AW)) i_rd_ctl (
    .rclk_i       (rclk_i),
    .rst_ni       (rst_ni),
    .fwft_i       (fwft_i),
    .rd_en_i      (rd_en_i),
    .wptr_sync_g_i(wptr_sync_g),
    .mem_rdata_i  (mem_rdata),
    .raddr_o      (raddr),
    .rptr_g_o     (rptr_g),
    .rd_data_o    (rd_data_o),
    .rd_rdy_o     (rd_rdy_o)
  );
endmodule

// File: tb/test_dual_mode_fifo.sv
module test_dual_mode_fifo;
  localparam int DW    = 36;
  localparam int DEPTH = 16;

  logic          wclk, rclk, rst_n, fwft, wr_en, rd_en;
  logic [DW-1:0] wr_data, rd_data;
  logic          wr_rdy, rd_rdy;
  int total = 0;
  int bad   = 0;

  localparam logic [DW-1:0] VEC [8] = '{
    36'h0_0000_0001, 36'hF_FFFF_FFFF, 36'hA_5A5A_5A5A, 36'h5_A5A5_A5A5,
    36'h8_0000_0000, 36'h0_0000_0000, 36'h1_2345_6789, 36'hE_DCBA_9876
  };
  localparam logic [DW-1:0] BAD_WORD = 36'hB_ADBA_DBAD;

  dual_mode_fifo #(.DEPTH(DEPTH), .DW(DW)) i_dual_mode_fifo (
    .wclk_i   (wclk),
    .rclk_i   (rclk),
    .rst_ni   (rst_n),
    .fwft_i   (fwft),
    .wr_en_i  (wr_en),
    .wr_data_i(wr_data),
    .wr_rdy_o (wr_rdy),
    .rd_en_i  (rd_en),
    .rd_data_o(rd_data),
    .rd_rdy_o (rd_rdy)
  );

  initial begin
    wclk = 1'b0;
    forever #4 wclk = ~wclk;
  end

  initial begin
    rclk = 1'b0;
    #1;
    forever #6 rclk = ~rclk;
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; fwft = mode; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    repeat (3) @(posedge rclk);
    @(negedge wclk);
    chk("R1 wr_rdy during reset", DW'(wr_rdy), '0);
    chk("R1 rd_rdy during reset", DW'(rd_rdy), '0);
    rst_n = 1'b1;
    #1 chk("R1 wr_rdy before first edge", DW'(wr_rdy), '0);
    @(negedge wclk);
    chk("R1 wr_rdy after first edge", DW'(wr_rdy), 1);
    @(posedge rclk);
    @(negedge rclk);
    fwft = ~mode;  // R1: must be ignored from here on
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wclk);
    wr_en = 1'b1; wr_data = d;
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic wait_flag();
    int n = 0;
    @(negedge rclk);
    while (!rd_rdy && n < 60) begin
      @(negedge rclk);
      n++;
    end
  endtask

  task automatic pop(input logic mode, input logic [DW-1:0] exp, input string tag);
    wait_flag();
    if (mode) begin
      chk(tag, rd_data, exp);
      rd_en = 1'b1;
      @(negedge rclk);
      rd_en = 1'b0;
    end else begin
      rd_en = 1'b1;
      @(negedge rclk);
      rd_en = 1'b0;
      chk(tag, rd_data, exp);
    end
  endtask

  task automatic latency_test(input logic mode);
    logic [DW-1:0] w = 36'h3_C3C3_0F0F;
    do_reset(mode);
    @(negedge wclk);
    wr_en = 1'b1; wr_data = w;
    @(posedge wclk);
    fork
      begin @(negedge wclk); wr_en = 1'b0; end
    join_none
    @(posedge rclk); @(negedge rclk);
    chk(mode ? "R4 flag low after edge 1" : "R2 flag low after edge 1", DW'(rd_rdy), '0);
    @(posedge rclk); @(negedge rclk);
    if (!mode) begin
      chk("R2 flag high after edge 2", DW'(rd_rdy), 1);
      chk("R3 no autoload at flag rise", rd_data, '0);
      repeat (3) @(negedge rclk);
      chk("R3 output held without request", rd_data, '0);
      pop(mode, w, "R3 explicit read delivers first word");
    end else begin
      chk("R4 flag low after edge 2", DW'(rd_rdy), '0);
      @(posedge rclk); @(negedge rclk);
      chk("R4 flag high after edge 3", DW'(rd_rdy), 1);
      chk("R4 word at output with flag", rd_data, w);
      repeat (3) @(negedge rclk);
      chk("R5 output held without read", rd_data, w);
      chk("R5 flag held without read", DW'(rd_rdy), 1);
      pop(mode, w, "R5 read of held word");
      chk("R5 flag drops when nothing left", DW'(rd_rdy), '0);
    end
  endtask

  task automatic vector_walk(input logic mode);
    do_reset(mode);
    for (int i = 0; i < 8; i++) push(VEC[i]);
    for (int i = 0; i < 8; i++) pop(mode, VEC[i], "R8 burst order");
    for (int i = 0; i < 8; i++) begin
      push(VEC[7-i]);
      pop(mode, VEC[7-i], "R8 interleaved");
    end
  endtask

  task automatic full_test(input logic mode);
    int cnt = 0;
    logic [DW-1:0] last;
    do_reset(mode);
    for (int i = 0; i < DEPTH + 4; i++) begin
      repeat (4) @(negedge wclk);
      if (wr_rdy) begin
        push(DW'(36'h100 + cnt));
        cnt++;
      end else begin
        wr_en = 1'b1; wr_data = BAD_WORD;
        @(negedge wclk);
        wr_en = 1'b0;
      end
    end
    chk("R6 accepted word count", DW'(cnt), DW'(DEPTH + (mode ? 1 : 0)));
    for (int i = 0; i < cnt; i++) pop(mode, DW'(36'h100 + i), "R6 drain after ignored write");
    repeat (6) @(negedge rclk);
    chk("R6 no extra word after drain", DW'(rd_rdy), '0);
    chk("R6 wr_rdy back after drain", DW'(wr_rdy), 1);
    // R7: read request while empty
    last = rd_data;
    @(negedge rclk);
    rd_en = 1'b1;
    repeat (2) @(negedge rclk);
    rd_en = 1'b0;
    chk("R7 empty read leaves output", rd_data, last);
    chk("R7 empty read leaves flag low", DW'(rd_rdy), '0);
    push(36'h7_7777_7777);
    pop(mode, 36'h7_7777_7777, "R7 next word after empty read");
  endtask

  task automatic concurrent_test(input logic mode);
    do_reset(mode);
    fork
      for (int i = 0; i < 24; i++) push(DW'(36'hC_0000_0000 + i * 3));
      for (int i = 0; i < 24; i++) pop(mode, DW'(36'hC_0000_0000 + i * 3), "R8 concurrent stream");
    join
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fwft = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    for (int m = 0; m < 2; m++) begin
      latency_test(m[0]);
      vector_walk(m[0]);
      full_test(m[0]);
      concurrent_test(m[0]);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule